// File: doc/BRIEF.md
# DDR PHY Training Step Sequencer

This block walks one memory channel through its physical-layer training steps for one rank at a time. Software drives it through a single dword command register. It holds mode bits, such as step skip masks, halt-on-timeout, the manual-step selection and the rank tag. It also accepts write-only trigger bits, which start a training pass or pulse the FIFO-pointer reset. The training engines themselves are outside the block. Each engine has a request line, which the sequencer holds high while that step is active, and a done line, which the engine pulses when the step has finished.

In automatic mode a pass runs the unmasked steps in a fixed order. A step that stays unfinished for a set number of cycles is a timeout. A timeout always sets a sticky fail flag. The halt bit decides whether the pass stops or moves on to the next step. In manual mode the sequencer enters only the step that software writes. It then stays in that step until software writes another one.

Alongside the sequencer the block provides several channel controls: a clock-enable drive for the DRAM, a one-cycle FIFO/bubble-generator reset pulse, and a gate on the read-return early-valid bit. It also issues one-cycle ZQ-calibration-long and impedance-compensation requests, each tagged with the rank.

Top module: `ddr_train_seq`

## Requirements
- R1: After reset, `rd_data`, `cur_state`, `step_go`, `busy`, `fail`, `train_done`, `cke_out`, `fifo_rst`, `zq_req`, `rcomp_req` and `rx_valid_out` are all zero.
- R2: Command register bits 1 to 9 and 11 to 16 read back on `rd_data` as last written. Bits 0, 10, 17 and all bits above 17 always read as 0.
- R3: Writing bit 0 = 1 with bit 1 = 0 while idle starts an automatic pass. Steps use the codes 1 = read DQ-DQS, 2 = receive-enable bitlock, 3 = write leveling and 4 = write DQ-DQS. The pass runs them in the order 2, 1, 3, 4. During a step, `cur_state` shows its code and `step_go[code-1]` stays high until `step_done[code-1]` is seen. After the last step the block returns to code 0 (idle), sets `train_done` and drops `busy`.
- R4: In automatic mode, bit 11 skips step 2, bit 12 skips step 1, bit 13 skips step 3 and bit 14 skips step 4. With all four bits set, a pass sets `train_done` without entering any step.
- R5: A step whose done line does not arrive within `STEP_TMO_CYC` cycles times out and sets `fail`, which stays set. With bit 8 = 0, the pass goes on to the next unmasked step and still ends with `train_done`.
- R6: With bit 8 = 1 in automatic mode, a timeout halts the pass at idle with `fail` = 1 and `train_done` = 0. No later step is entered.
- R7: With bit 1 = 1, every register write moves `cur_state` to the code in bits 4:2, and codes 5 to 7 are taken as idle. `step_go` for that step stays high until its done line arrives or it times out, which sets `fail`. The state then stays put. Bit 0 has no effect in this mode.
- R8: At most one bit of `step_go` is high. Any high bit implies `busy`, and `step_go` is zero while `cur_state` is idle.
- R9: Each write with bit 10 = 1 gives a `fifo_rst` pulse exactly one cycle long on the clock edge after the write.
- R10: `rx_valid_out` follows `rx_valid_in` one cycle later. It is forced to 0 while bit 9 is set.
- R11: Writing bit 17 = 1 drives every `cke_out` bit high, and they stay high until a write with bit 17 = 0. While `init_done` is high, `cke_out` is all zero.
- R12: Each write with bit 15 = 1 gives a single one-cycle `zq_req` pulse, and each write with bit 16 = 1 gives a single one-cycle `rcomp_req` pulse. In both cases `req_rank` carries bits 7:5 of that write. The register bits themselves stay set.
- R13: Starting a new automatic pass clears `fail` and `train_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | DATA_W | Command register write data |
| rd_data | output | DATA_W | Command register readback |
| init_done | input | 1 | Initialisation complete; releases the clock-enable drive |
| step_done | input | 4 | Done pulses from the step engines, bit = code-1 |
| step_go | output | 4 | Step request lines, bit = code-1 |
| cur_state | output | 3 | Current step code |
| busy | output | 1 | A step is active |
| fail | output | 1 | Sticky timeout flag |
| train_done | output | 1 | Automatic pass completed |
| cke_out | output | N_CKE | Clock-enable drive |
| fifo_rst | output | 1 | FIFO pointer and bubble-generator reset pulse |
| rx_valid_in | input | 1 | Early-valid from the receive FIFOs |
| rx_valid_out | output | 1 | Gated early-valid |
| zq_req | output | 1 | ZQ calibration long request pulse |
| rcomp_req | output | 1 | Impedance compensation request pulse |
| req_rank | output | 3 | Rank tag for the calibration requests |

## Verification
The sequencer is tried with eight mask/hang/halt patterns: no mask, one skipped step, two skipped steps and all skipped, each with engines that answer; then a hang with the halt bit clear, and a hang with it set, both at a middle step and at the last step. The order of visited codes tells apart ordering faults, wrong mask-to-step mapping and a wrong choice between continuing and halting after a timeout. A clean pass after a failed one shows whether the flags clear. Manual stepping is tried with a valid code, with out-of-range code 7, with the start bit written in manual mode, and with a hung engine, which separates "enter and wait" from automatic advance. The side controls are checked by counting their pulses and by toggling `init_done` against a held clock-enable.

// File: rtl/trn_pkg.sv
package trn_pkg;
  // command register field positions (decoded by the sequencer and side controls)
  localparam int B_TRAIN   = 0;
  localparam int B_MANUAL  = 1;
  localparam int B_NXT_LO  = 2;
  localparam int B_RANK_LO = 5;
  localparam int B_HALT    = 8;
  localparam int B_IGNRX   = 9;
  localparam int B_FIFORST = 10;
  localparam int B_SKIP_LO = 11;
  localparam int B_ZQ      = 15;
  localparam int B_RC      = 16;
  localparam int B_CKE     = 17;
  localparam int REG_W     = 17;  // bits 16:0 kept in the register file
  localparam int N_STEP    = 4;
  localparam int RANK_W    = 3;
  localparam int CODE_W    = 3;

  // step codes
  localparam logic [CODE_W-1:0] ST_IDLE  = 3'd0;
  localparam logic [CODE_W-1:0] ST_RDDQ  = 3'd1;
  localparam logic [CODE_W-1:0] ST_RCVEN = 3'd2;
  localparam logic [CODE_W-1:0] ST_WRLVL = 3'd3;
  localparam logic [CODE_W-1:0] ST_WRDQ  = 3'd4;

  // position in the automatic order -> step code; skip mask bits follow this order
  function automatic logic [CODE_W-1:0] order_code(input int p);
    case (p)
      0:       order_code = ST_RCVEN;
      1:       order_code = ST_RDDQ;
      2:       order_code = ST_WRLVL;
      default: order_code = ST_WRDQ;
    endcase
  endfunction

  // first unskipped step after cur in the automatic order, or idle
  function automatic logic [CODE_W-1:0] next_step(input logic [CODE_W-1:0] cur,
                                                  input logic [N_STEP-1:0] skip);
    int start;
    logic [CODE_W-1:0] res;
    start = 0;
    res   = ST_IDLE;
    for (int p = 0; p < N_STEP; p++)
      if (order_code(p) == cur) start = p + 1;
    for (int p = N_STEP - 1; p >= 0; p--)
      if (p >= start && !skip[p]) res = order_code(p);
    return res;
  endfunction
endpackage

// File: rtl/trn_cmd_reg.sv
module trn_cmd_reg
  import trn_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] reg_q,
  output logic             train_p,
  output logic             man_wr_p
);
  // write-only bits and the upper field never enter the register file
  localparam logic [REG_W-1:0] KEEP_MASK =
    ~((REG_W'(1) << B_TRAIN) | (REG_W'(1) << B_FIFORST));

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= '0;
      train_p  <= 1'b0;
      man_wr_p <= 1'b0;
    end else begin
      if (wr_en) reg_q <= wr_data & KEEP_MASK;
      train_p  <= wr_en & wr_data[B_TRAIN];
      man_wr_p <= wr_en & wr_data[B_MANUAL];
    end
  end
endmodule

// File: rtl/trn_step_fsm.sv
module trn_step_fsm
  import trn_pkg::*;
#(
  parameter int STEP_TMO_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              manual,
  input  logic              halt_on_tmo,
  input  logic [N_STEP-1:0] skip,
  input  logic [CODE_W-1:0] nxt_req,
  input  logic              train_p,
  input  logic              man_wr_p,
  input  logic [N_STEP-1:0] step_done,
  output logic [N_STEP-1:0] step_go,
  output logic [CODE_W-1:0] state_q,
  output logic              active_q,
  output logic              fail_q,
  output logic              done_q
);
  localparam int TW = $clog2(STEP_TMO_CYC + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(STEP_TMO_CYC - 1);

  logic          run_q;
  logic [TW-1:0] tmr_q;
  logic          done_hit, tmo_hit;
  logic [CODE_W-1:0] step_after, step_first;

  for (genvar i = 0; i < N_STEP; i++) begin : g_go
    assign step_go[i] = active_q && (state_q == CODE_W'(i + 1));
  end

  assign done_hit   = |(step_done & step_go);
  assign tmo_hit    = active_q && !done_hit && (tmr_q == TMO_LAST);
  assign step_after = next_step(state_q, skip);
  assign step_first = next_step(ST_IDLE, skip);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      active_q <= 1'b0;
      run_q    <= 1'b0;
      tmr_q    <= '0;
      fail_q   <= 1'b0;
      done_q   <= 1'b0;
    end else if (manual) begin
      run_q <= 1'b0;
      if (man_wr_p) begin
        tmr_q <= '0;
        if (nxt_req >= ST_RDDQ && nxt_req <= ST_WRDQ) begin
          state_q  <= nxt_req;
          active_q <= 1'b1;
        end else begin
          state_q  <= ST_IDLE;
          active_q <= 1'b0;
        end
      end else if (active_q) begin
        if (done_hit) active_q <= 1'b0;
        else if (tmo_hit) begin
          active_q <= 1'b0;
          fail_q   <= 1'b1;
        end else tmr_q <= tmr_q + 1'b1;
      end
    end else if (run_q) begin
      if (done_hit || tmo_hit) begin
        tmr_q <= '0;
        if (tmo_hit) fail_q <= 1'b1;
        if (tmo_hit && halt_on_tmo) begin
          state_q  <= ST_IDLE;
          active_q <= 1'b0;
          run_q    <= 1'b0;
        end else if (step_after == ST_IDLE) begin
          state_q  <= ST_IDLE;
          active_q <= 1'b0;
          run_q    <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          state_q <= step_after;
        end
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end else if (train_p) begin
      fail_q <= 1'b0;
      tmr_q  <= '0;
      if (step_first == ST_IDLE) begin
        done_q <= 1'b1;
      end else begin
        done_q   <= 1'b0;
        state_q  <= step_first;
        active_q <= 1'b1;
        run_q    <= 1'b1;
      end
    end else begin
      state_q  <= ST_IDLE;
      active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/trn_side_ctl.sv
module trn_side_ctl
  import trn_pkg::*;
#(
  parameter int N_CKE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_cke,
  input  logic              wr_fifo,
  input  logic              wr_zq,
  input  logic              wr_rc,
  input  logic [RANK_W-1:0] wr_rank,
  input  logic              ign_rx,
  input  logic              init_done,
  input  logic              rx_valid_in,
  output logic [N_CKE-1:0]  cke_out,
  output logic              fifo_rst,
  output logic              rx_valid_out,
  output logic              zq_req,
  output logic              rcomp_req,
  output logic [RANK_W-1:0] req_rank
);
  logic cke_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_hold     <= 1'b0;
      cke_out      <= '0;
      fifo_rst     <= 1'b0;
      rx_valid_out <= 1'b0;
      zq_req       <= 1'b0;
      rcomp_req    <= 1'b0;
      req_rank     <= '0;
    end else begin
      if (wr_en) cke_hold <= wr_cke;
      cke_out      <= {N_CKE{cke_hold & ~init_done}};
      fifo_rst     <= wr_en & wr_fifo;
      rx_valid_out <= rx_valid_in & ~ign_rx;
      zq_req       <= wr_en & wr_zq;
      rcomp_req    <= wr_en & wr_rc;
      if (wr_en && (wr_zq || wr_rc)) req_rank <= wr_rank;
    end
  end
endmodule

// File: rtl/ddr_train_seq.sv
module ddr_train_seq
  import trn_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int N_CKE        = 2,
  parameter int STEP_TMO_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              init_done,
  input  logic [N_STEP-1:0] step_done,
  output logic [N_STEP-1:0] step_go,
  output logic [CODE_W-1:0] cur_state,
  output logic              busy,
  output logic              fail,
  output logic              train_done,
  output logic [N_CKE-1:0]  cke_out,
  output logic              fifo_rst,
  input  logic              rx_valid_in,
  output logic              rx_valid_out,
  output logic              zq_req,
  output logic              rcomp_req,
  output logic [RANK_W-1:0] req_rank
);
  logic [REG_W-1:0] reg_q;
  logic             train_p, man_wr_p;
  logic             unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:B_CKE+1];
  assign rd_data   = DATA_W'(reg_q);

  trn_cmd_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data[REG_W-1:0]),
    .reg_q    (reg_q),
    .train_p  (train_p),
    .man_wr_p (man_wr_p)
  );

  trn_step_fsm #(.STEP_TMO_CYC(STEP_TMO_CYC)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .manual      (reg_q[B_MANUAL]),
    .halt_on_tmo (reg_q[B_HALT]),
    .skip        (reg_q[B_SKIP_LO +: N_STEP]),
    .nxt_req     (reg_q[B_NXT_LO +: CODE_W]),
    .train_p     (train_p),
    .man_wr_p    (man_wr_p),
    .step_done   (step_done),
    .step_go     (step_go),
    .state_q     (cur_state),
    .active_q    (busy),
    .fail_q      (fail),
    .done_q      (train_done)
  );

  trn_side_ctl #(.N_CKE(N_CKE)) u_side (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_cke       (wr_data[B_CKE]),
    .wr_fifo      (wr_data[B_FIFORST]),
    .wr_zq        (wr_data[B_ZQ]),
    .wr_rc        (wr_data[B_RC]),
    .wr_rank      (wr_data[B_RANK_LO +: RANK_W]),
    .ign_rx       (reg_q[B_IGNRX]),
    .init_done    (init_done),
    .rx_valid_in  (rx_valid_in),
    .cke_out      (cke_out),
    .fifo_rst     (fifo_rst),
    .rx_valid_out (rx_valid_out),
    .zq_req       (zq_req),
    .rcomp_req    (rcomp_req),
    .req_rank     (req_rank)
  );
endmodule

// File: rtl/ddr_train_seq_chk.sv
module ddr_train_seq_chk #(
  parameter int N_CKE = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_fifo,
  input logic             wr_zq,
  input logic             wr_rc,
  input logic             init_done,
  input logic [3:0]       step_go,
  input logic [2:0]       cur_state,
  input logic             busy,
  input logic [N_CKE-1:0] cke_out,
  input logic             fifo_rst,
  input logic             rx_valid_in,
  input logic             rx_valid_out,
  input logic             zq_req,
  input logic             rcomp_req
);
  p_go_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_go));
  p_go_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (step_go != 4'b0) |-> busy);
  p_go_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (cur_state == 3'd0) |-> (step_go == 4'b0));
  p_fifo_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_rst |-> $past(wr_en && wr_fifo));
  p_rx_gate_r10: assert property (@(posedge clk) disable iff (rst)
    rx_valid_out |-> $past(rx_valid_in));
  p_cke_release_r11: assert property (@(posedge clk) disable iff (rst)
    init_done |=> (cke_out == '0));
  p_zq_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    zq_req |-> $past(wr_en && wr_zq));
  p_rc_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    rcomp_req |-> $past(wr_en && wr_rc));
endmodule

bind ddr_train_seq ddr_train_seq_chk #(.N_CKE(N_CKE)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_fifo      (wr_data[10]),
  .wr_zq        (wr_data[15]),
  .wr_rc        (wr_data[16]),
  .init_done    (init_done),
  .step_go      (step_go),
  .cur_state    (cur_state),
  .busy         (busy),
  .cke_out      (cke_out),
  .fifo_rst     (fifo_rst),
  .rx_valid_in  (rx_valid_in),
  .rx_valid_out (rx_valid_out),
  .zq_req       (zq_req),
  .rcomp_req    (rcomp_req)
);

// File: tb/ddr_train_seq_bench.sv
module ddr_train_seq_bench;
  localparam int N_CKE = 2;
  localparam int TMO   = 16;
  localparam int LAT   = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        init_done = 1'b0;
  logic [3:0]  step_done = '0;
  logic [3:0]  step_go;
  logic [2:0]  cur_state;
  logic        busy, fail, train_done;
  logic [N_CKE-1:0] cke_out;
  logic        fifo_rst, rx_valid_in, rx_valid_out, zq_req, rcomp_req;
  logic [2:0]  req_rank;

  int nchk = 0, nerr = 0;
  bit fin = 1'b0;
  logic [2:0] hang_code = 3'd0;
  logic [2:0] log_a [8];
  int log_n = 0;

  always #10 clk = ~clk;  // 50 MHz

  ddr_train_seq #(.DATA_W(32), .N_CKE(N_CKE), .STEP_TMO_CYC(TMO)) u_ddr_train_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .init_done(init_done), .step_done(step_done), .step_go(step_go),
    .cur_state(cur_state), .busy(busy), .fail(fail), .train_done(train_done),
    .cke_out(cke_out), .fifo_rst(fifo_rst), .rx_valid_in(rx_valid_in),
    .rx_valid_out(rx_valid_out), .zq_req(zq_req), .rcomp_req(rcomp_req),
    .req_rank(req_rank));

  // vector: [9:6] skip mask (bits 14:11), [5:3] hung step code, [2] halt, [1] exp fail, [0] exp done
  localparam logic [9:0] VEC [8] = '{
    10'b0000_000_0_0_1, 10'b0001_000_0_0_1, 10'b1010_000_0_0_1, 10'b1111_000_0_0_1,
    10'b0000_011_0_1_1, 10'b0000_001_1_1_0, 10'b0000_000_0_0_1, 10'b0100_100_1_1_0};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic wait_idle();
    int n = 0;
    repeat (3) @(negedge clk);
    while (busy && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [2:0] pos_code(input int p);
    case (p)
      0: return 3'd2;
      1: return 3'd1;
      2: return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  // step engines: answer a request after LAT cycles unless that step is hung
  initial begin
    int cnt [4] = '{0, 0, 0, 0};
    forever begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        step_done[i] = 1'b0;
        if (step_go[i] && (hang_code != 3'(i + 1))) begin
          if (cnt[i] == LAT) begin
            step_done[i] = 1'b1;
            cnt[i] = 0;
          end else cnt[i]++;
        end else if (!step_go[i]) cnt[i] = 0;
      end
    end
  end

  // record every step code entered
  initial begin
    logic [2:0] prev = 3'd0;
    forever begin
      @(negedge clk);
      if (cur_state != prev && cur_state != 3'd0 && log_n < 8) begin
        log_a[log_n] = cur_state;
        log_n++;
      end
      prev = cur_state;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rx_valid_in = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rd_data == 0 && cur_state == 0 && step_go == 0 && !busy && !fail && !train_done,
          "R1 core", {busy, fail, train_done, 1'b0, step_go, 1'b0, cur_state}, 0);
    check(cke_out == 0 && !fifo_rst && !zq_req && !rcomp_req && !rx_valid_out,
          "R1 side", {cke_out, fifo_rst, zq_req, rcomp_req, rx_valid_out}, 0);

    // R3 R4 R5 R6 R13 automatic passes from the table
    for (int v = 0; v < 8; v++) begin
      logic [3:0] m;
      logic [2:0] exp_seq [4];
      int exp_n;
      bit ok;
      m = VEC[v][9:6];
      hang_code = VEC[v][5:3];
      exp_n = 0;
      for (int p = 0; p < 4; p++) begin
        if (!m[p]) begin
          exp_seq[exp_n] = pos_code(p);
          exp_n++;
          if (pos_code(p) == hang_code && VEC[v][2]) break;
        end
      end
      log_n = 0;
      wr((32'(m) << 11) | (32'(VEC[v][2]) << 8) | (32'd3 << 5) | 32'd1);
      wait_idle();
      ok = (log_n == exp_n);
      for (int k = 0; k < 4; k++)
        if (k < exp_n && k < log_n && log_a[k] != exp_seq[k]) ok = 1'b0;
      check(ok, "R3/R4 step order", 32'(log_n), 32'(exp_n));
      check(fail == VEC[v][1], "R5/R6/R13 fail flag", 32'(fail), 32'(VEC[v][1]));
      check(train_done == VEC[v][0], "R3/R6/R13 done flag", 32'(train_done), 32'(VEC[v][0]));
      check(!busy && cur_state == 0, "R3 back to idle", 32'(cur_state), 0);
    end
    hang_code = 3'd0;

    // R2 readback of all-ones write (autodis set so no pass starts)
    wr(32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    check(rd_data == 32'h0001_FBFE, "R2 readback", rd_data, 32'h0001_FBFE);
    wr(32'h0);
    repeat (3) @(negedge clk);
    check(rd_data == 0, "R2 cleared", rd_data, 0);

    // R7 manual stepping
    log_n = 0;
    wr(32'h2 | (32'd3 << 2));
    @(negedge clk);
    check(cur_state == 3 && step_go == 4'b0100, "R7 manual enter", {cur_state, step_go}, {3'd3, 4'b0100});
    repeat (10) @(negedge clk);
    check(cur_state == 3 && !busy && step_go == 0, "R7 manual hold", {busy, cur_state}, 3);
    wr(32'h2 | 32'h1);
    repeat (6) @(negedge clk);
    check(cur_state == 0 && !busy && !train_done, "R7 start ignored", {busy, train_done, cur_state}, 0);
    wr(32'h2 | (32'd7 << 2));
    repeat (3) @(negedge clk);
    check(cur_state == 0 && !busy, "R7 code 7 idle", 32'(cur_state), 0);
    hang_code = 3'd1;
    wr(32'h2 | (32'd1 << 2));
    repeat (TMO + 6) @(negedge clk);
    check(fail && !busy && cur_state == 1, "R7 manual timeout", {fail, busy, cur_state}, {1'b1, 1'b0, 3'd1});
    hang_code = 3'd0;
    wr(32'h0);
    repeat (3) @(negedge clk);

    // R9 fifo reset pulse
    begin
      int c = 0;
      wr(32'h400);
      for (int k = 0; k < 6; k++) begin
        if (fifo_rst) c++;
        @(negedge clk);
      end
      check(c == 1, "R9 fifo pulse count", 32'(c), 1);
      check(rd_data[10] == 1'b0, "R9 readback zero", 32'(rd_data[10]), 0);
    end

    // R12 calibration requests
    begin
      int cz = 0, cr = 0;
      logic [2:0] rk = 3'd0;
      wr(32'h8000 | (32'd5 << 5));
      for (int k = 0; k < 6; k++) begin
        if (zq_req) begin cz++; rk = req_rank; end
        if (rcomp_req) cr++;
        @(negedge clk);
      end
      check(cz == 1 && cr == 0, "R12 zq pulse", {16'(cz), 16'(cr)}, 32'h0001_0000);
      check(rk == 3'd5, "R12 zq rank", 32'(rk), 5);
      check(rd_data[15] == 1'b1, "R12 zq bit held", 32'(rd_data[15]), 1);
      cz = 0; cr = 0;
      wr(32'h1_0000 | (32'd6 << 5));
      for (int k = 0; k < 6; k++) begin
        if (rcomp_req) begin cr++; rk = req_rank; end
        if (zq_req) cz++;
        @(negedge clk);
      end
      check(cr == 1 && cz == 0 && rk == 3'd6, "R12 rcomp pulse", {16'(cr), 13'(cz), rk}, {16'd1, 13'd0, 3'd6});
    end

    // R10 receive gating
    rx_valid_in = 1'b1;
    wr(32'h200);
    repeat (3) @(negedge clk);
    check(rx_valid_out == 1'b0, "R10 gated", 32'(rx_valid_out), 0);
    wr(32'h0);
    repeat (3) @(negedge clk);
    check(rx_valid_out == 1'b1, "R10 pass", 32'(rx_valid_out), 1);
    rx_valid_in = 1'b0;

    // R11 clock enable drive
    wr(32'h2_0000);
    repeat (3) @(negedge clk);
    check(cke_out == '1, "R11 cke on", 32'(cke_out), 32'(N_CKE'('1)));
    init_done = 1'b1;
    repeat (2) @(negedge clk);
    check(cke_out == '0, "R11 init_done release", 32'(cke_out), 0);
    init_done = 1'b0;
    repeat (2) @(negedge clk);
    check(cke_out == '1, "R11 cke held", 32'(cke_out), 32'(N_CKE'('1)));
    wr(32'h0);
    repeat (3) @(negedge clk);
    check(cke_out == '0, "R11 cke off", 32'(cke_out), 0);

    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule